// File: doc/BRIEF.md
# Legacy-Aware Bridge Address Router

This block sits behind the host side of a bridge that leads to a secondary graphics port. For each CPU-initiated request it decides whether the request crosses to the secondary port or stays on the primary bus. The request arrives as an address, a memory-or-I/O flag and a valid strobe. The routing decision is registered and appears one cycle later, qualified by its own valid flag.

The decision comes from three sources. The first is a programmable I/O window. The second is a pair of memory windows, one regular and one prefetchable. Each window is a base/limit pair that arrives as an input. The third is two control bits. The legacy display bit claims the classic display memory and I/O ranges for the secondary port, whatever the windows say. The legacy expansion bit removes the upper three quarters of every 1 KB I/O block from the I/O window. This leaves those addresses on the primary bus, where an expansion bus bridge can claim them.

Top module: `brt_addr_router`

## Requirements
- R1: While `rst` is high, `route_valid` and `route_secondary` are 0 on the following cycle, whatever the request inputs are.
- R2: `route_valid` equals `req_valid` from one clock earlier, and `route_secondary` is 0 whenever `route_valid` is 0.
- R3: With `vga_en`=1, a memory request (`req_is_io`=0) whose address lies from 0x000A0000 through 0x000BFFFF inclusive routes to the secondary port (`route_secondary`=1).
- R4: With `vga_en`=1, an I/O request whose address bits [9:0] lie in 0x3B0–0x3BB or 0x3C0–0x3DF routes to the secondary port, whatever address bits [15:10] hold.
- R5: Legacy display forwarding under R3/R4 holds even when the address is outside every window and when `isa_en`=1.
- R6: With `vga_en`=0, a request in a legacy display range routes to the secondary port only when a window covers it. Otherwise it stays primary.
- R7: A window matches when base <= address <= limit, inclusive at both ends. A window whose base exceeds its limit matches nothing.
- R8: A memory request routes to the secondary port when it falls in either the regular window (`mem_base`/`mem_limit`) or the prefetchable window (`pmem_base`/`pmem_limit`).
- R9: With `isa_en`=1, an I/O request inside the I/O window whose address bits [9:8] are not 00 stays primary, unless R4 applies.
- R10: With `isa_en`=0, every I/O request inside the I/O window routes to the secondary port. The I/O window compares address bits [15:0] only.
- R11: An I/O request outside the I/O window, and outside the legacy display ranges when `vga_en`=1, stays primary regardless of `isa_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | ADDR_W | Request address |
| vga_en | input | 1 | Legacy display range forwarding enable |
| isa_en | input | 1 | Legacy expansion I/O carve-out enable |
| io_base | input | IO_W | I/O window lower bound (inclusive) |
| io_limit | input | IO_W | I/O window upper bound (inclusive) |
| mem_base | input | ADDR_W | Regular memory window lower bound |
| mem_limit | input | ADDR_W | Regular memory window upper bound |
| pmem_base | input | ADDR_W | Prefetchable memory window lower bound |
| pmem_limit | input | ADDR_W | Prefetchable memory window upper bound |
| route_valid | output | 1 | Decision below is valid (one cycle after request) |
| route_secondary | output | 1 | 1 = forward to secondary port, 0 = stay primary |

## Verification
The properties assume that the control bits and the window registers stay stable between a request and its decision. This matters because each property pairs the request cycle with the output of the next cycle, and the memory properties read `vga_en` and the address range only at request time. The stimulus changes the window and control settings only while `req_valid` is low, or between sweeps. Within a sweep it changes only the address and type, one request per cycle. Each sweep covers every I/O address up to 0x1FFF, so ISA aliases of the display ranges are included, along with dense memory steps across the legacy display hole and explicit probes on each window edge.

// File: rtl/brt_pkg.sv
package brt_pkg;

  // Legacy display memory hole (inclusive bounds)
  localparam logic [31:0] LEGACY_MEM_FIRST = 32'h000A_0000;
  localparam logic [31:0] LEGACY_MEM_LAST  = 32'h000B_FFFF;

  // Legacy display I/O ranges, matched on the low alias bits only
  localparam int unsigned ALIAS_BITS       = 10;
  localparam logic [ALIAS_BITS-1:0] LEGACY_IO_A_FIRST = 10'h3B0;
  localparam logic [ALIAS_BITS-1:0] LEGACY_IO_A_LAST  = 10'h3BB;
  localparam logic [ALIAS_BITS-1:0] LEGACY_IO_B_FIRST = 10'h3C0;
  localparam logic [ALIAS_BITS-1:0] LEGACY_IO_B_LAST  = 10'h3DF;

  // Quarter-select bits within a 1 KB I/O block
  localparam int unsigned QUARTER_MSB = 9;
  localparam int unsigned QUARTER_LSB = 8;

  typedef enum logic {
    PORT_PRIMARY   = 1'b0,
    PORT_SECONDARY = 1'b1
  } port_e;

  typedef struct packed {
    logic  valid;
    port_e port;
  } route_t;

endpackage

// File: rtl/brt_window_cmp.sv
module brt_window_cmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] limit,
  output logic         hit
);

  // Inclusive window; an inverted pair can never satisfy both bounds.
  always_comb begin
    hit = (addr >= base) && (addr <= limit);
  end

endmodule

// File: rtl/brt_vga_decode.sv
module brt_vga_decode
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              enable,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] MEM_FIRST = ADDR_W'(LEGACY_MEM_FIRST);
  localparam logic [ADDR_W-1:0] MEM_LAST  = ADDR_W'(LEGACY_MEM_LAST);

  logic [ALIAS_BITS-1:0] alias_off;
  logic                  io_match;
  logic                  mem_match;

  always_comb begin
    alias_off = addr[ALIAS_BITS-1:0];
    io_match  = ((alias_off >= LEGACY_IO_A_FIRST) && (alias_off <= LEGACY_IO_A_LAST)) ||
                ((alias_off >= LEGACY_IO_B_FIRST) && (alias_off <= LEGACY_IO_B_LAST));
    mem_match = (addr >= MEM_FIRST) && (addr <= MEM_LAST);
    hit       = enable && (is_io ? io_match : mem_match);
  end

endmodule

// File: rtl/brt_isa_filter.sv
module brt_isa_filter (
  input  logic       enable,
  input  logic [1:0] quarter,
  output logic       block
);

  // Only the first 256 bytes of each 1 KB block pass to the secondary side.
  always_comb begin
    block = enable && (quarter != 2'b00);
  end

endmodule

// File: rtl/brt_addr_router.sv
module brt_addr_router
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              vga_en,
  input  logic              isa_en,
  input  logic [IO_W-1:0]   io_base,
  input  logic [IO_W-1:0]   io_limit,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] mem_limit,
  input  logic [ADDR_W-1:0] pmem_base,
  input  logic [ADDR_W-1:0] pmem_limit,
  output logic              route_valid,
  output logic              route_secondary
);

  localparam int unsigned NUM_MEM_WIN = 2;

  logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] win_base;
  logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] win_limit;
  logic [NUM_MEM_WIN-1:0]             mem_win_hit;

  logic   io_win_hit;
  logic   legacy_hit;
  logic   isa_block;
  logic   io_fwd;
  logic   mem_fwd;
  port_e  next_port;
  route_t route_q;

  assign win_base[0]  = mem_base;
  assign win_limit[0] = mem_limit;
  assign win_base[1]  = pmem_base;
  assign win_limit[1] = pmem_limit;

  for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_mem_win
    brt_window_cmp #(.W(ADDR_W)) u_mem_win (
      .addr  (req_addr),
      .base  (win_base[g]),
      .limit (win_limit[g]),
      .hit   (mem_win_hit[g])
    );
  end

  brt_window_cmp #(.W(IO_W)) u_io_win (
    .addr  (req_addr[IO_W-1:0]),
    .base  (io_base),
    .limit (io_limit),
    .hit   (io_win_hit)
  );

  brt_vga_decode #(.ADDR_W(ADDR_W)) u_legacy (
    .enable (vga_en),
    .is_io  (req_is_io),
    .addr   (req_addr),
    .hit    (legacy_hit)
  );

  brt_isa_filter u_isa (
    .enable  (isa_en),
    .quarter (req_addr[QUARTER_MSB:QUARTER_LSB]),
    .block   (isa_block)
  );

  always_comb begin
    io_fwd  = io_win_hit && !isa_block;
    mem_fwd = |mem_win_hit;
    if (legacy_hit || (req_is_io ? io_fwd : mem_fwd)) begin
      next_port = PORT_SECONDARY;
    end else begin
      next_port = PORT_PRIMARY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
    end else begin
      route_q.valid <= req_valid;
      route_q.port  <= req_valid ? next_port : PORT_PRIMARY;
    end
  end

  assign route_valid     = route_q.valid;
  assign route_secondary = (route_q.port == PORT_SECONDARY);

endmodule

// File: rtl/brt_addr_router_chk.sv
module brt_addr_router_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IO_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic              vga_en,
  input logic              isa_en,
  input logic [IO_W-1:0]   io_base,
  input logic [IO_W-1:0]   io_limit,
  input logic              route_valid,
  input logic              route_secondary
);

  logic mem_legacy;
  logic io_legacy;
  logic io_in_win;

  always_comb begin
    mem_legacy = (req_addr >= ADDR_W'(32'h000A_0000)) && (req_addr <= ADDR_W'(32'h000B_FFFF));
    io_legacy  = ((req_addr[9:0] >= 10'h3B0) && (req_addr[9:0] <= 10'h3BB)) ||
                 ((req_addr[9:0] >= 10'h3C0) && (req_addr[9:0] <= 10'h3DF));
    io_in_win  = (req_addr[IO_W-1:0] >= io_base) && (req_addr[IO_W-1:0] <= io_limit);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!route_valid && !route_secondary));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> route_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !route_valid);

  p_sec_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    route_secondary |-> route_valid);

  p_legacy_mem_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_io && vga_en && mem_legacy) |=> route_secondary);

  p_legacy_io_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && vga_en && io_legacy) |=> route_secondary);

  p_empty_io_win_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && !vga_en && (io_base > io_limit)) |=> !route_secondary);

  p_isa_carve_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && !vga_en && isa_en && (req_addr[9:8] != 2'b00)) |=> !route_secondary);

  p_isa_off_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && !isa_en && io_in_win) |=> route_secondary);

  p_outside_io_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && !vga_en && !io_in_win) |=> !route_secondary);

endmodule

bind brt_addr_router brt_addr_router_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_is_io       (req_is_io),
  .req_addr        (req_addr),
  .vga_en          (vga_en),
  .isa_en          (isa_en),
  .io_base         (io_base),
  .io_limit        (io_limit),
  .route_valid     (route_valid),
  .route_secondary (route_secondary)
);

// File: tb/brt_addr_router_test.sv
module brt_addr_router_test;

  localparam int unsigned AW = 32;
  localparam int unsigned IW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_is_io;
  logic [AW-1:0] req_addr;
  logic          vga_en;
  logic          isa_en;
  logic [IW-1:0] io_base;
  logic [IW-1:0] io_limit;
  logic [AW-1:0] mem_base;
  logic [AW-1:0] mem_limit;
  logic [AW-1:0] pmem_base;
  logic [AW-1:0] pmem_limit;
  logic          route_valid;
  logic          route_secondary;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  brt_addr_router #(.ADDR_W(AW), .IO_W(IW)) uut (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_is_io       (req_is_io),
    .req_addr        (req_addr),
    .vga_en          (vga_en),
    .isa_en          (isa_en),
    .io_base         (io_base),
    .io_limit        (io_limit),
    .mem_base        (mem_base),
    .mem_limit       (mem_limit),
    .pmem_base       (pmem_base),
    .pmem_limit      (pmem_limit),
    .route_valid     (route_valid),
    .route_secondary (route_secondary)
  );

  function automatic bit legacy_range(input bit io, input logic [AW-1:0] a);
    int unsigned lo;
    lo = a % 1024;
    if (io) return ((lo >= 'h3B0) && (lo <= 'h3BB)) || ((lo >= 'h3C0) && (lo <= 'h3DF));
    return (a >= 32'h000A_0000) && (a <= 32'h000B_FFFF);
  endfunction

  function automatic bit io_window(input logic [AW-1:0] a);
    int unsigned a16;
    a16 = a % 65536;
    return (a16 >= io_base) && (a16 <= io_limit);
  endfunction

  function automatic bit mem_window(input logic [AW-1:0] a);
    return ((a >= mem_base) && (a <= mem_limit)) || ((a >= pmem_base) && (a <= pmem_limit));
  endfunction

  function automatic bit expect_sec(input bit io, input logic [AW-1:0] a);
    int unsigned quarter;
    if (vga_en && legacy_range(io, a)) return 1'b1;
    if (!io) return mem_window(a);
    quarter = (a % 1024) / 256;
    if (!io_window(a)) return 1'b0;
    if (isa_en && quarter != 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string pick_tag(input bit io, input logic [AW-1:0] a);
    bit win;
    win = io ? io_window(a) : mem_window(a);
    if (legacy_range(io, a)) begin
      if (!vga_en) return "R6";
      if (isa_en || !win) return "R5";
      return io ? "R4" : "R3";
    end
    if (!io) return "R8";
    if (io_base > io_limit) return "R7";
    if (!win) return "R11";
    if (isa_en) return "R9";
    return "R10";
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  // Called at a negedge; drives one request and samples its decision at the next negedge.
  task automatic step(input bit io, input logic [AW-1:0] a, input string force_tag);
    logic  exp;
    string tag;
    req_valid = 1'b1;
    req_is_io = io;
    req_addr  = a;
    exp = expect_sec(io, a);
    tag = (force_tag.len() != 0) ? force_tag : pick_tag(io, a);
    @(negedge clk);
    check_bit(route_valid, 1'b1, "R2", "valid after request");
    check_bit(route_secondary, exp, tag, $sformatf("route io=%0b addr=%h", io, a));
  endtask

  task automatic idle_cycle();
    req_valid = 1'b0;
    req_is_io = 1'b0;
    req_addr  = 32'h000A_1000;
    @(negedge clk);
    check_bit(route_valid, 1'b0, "R2", "valid low when idle");
    check_bit(route_secondary, 1'b0, "R2", "secondary low when idle");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst        = 1'b1;
    req_valid  = 1'b1;
    req_is_io  = 1'b0;
    req_addr   = 32'h000A_0000;
    vga_en     = 1'b1;
    isa_en     = 1'b1;
    io_base    = 16'h0000;
    io_limit   = 16'hFFFF;
    mem_base   = 32'h0000_0000;
    mem_limit  = 32'hFFFF_FFFF;
    pmem_base  = 32'h0000_0000;
    pmem_limit = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_bit(route_valid, 1'b0, "R1", "valid during reset");
    check_bit(route_secondary, 1'b0, "R1", "secondary during reset");
    req_valid = 1'b0;
    rst       = 1'b0;
    @(negedge clk);
    idle_cycle();

    // I/O sweeps: normal window, then inverted (empty) window
    for (int cfg = 0; cfg < 2; cfg++) begin
      io_base  = (cfg == 0) ? 16'h0300 : 16'h0800;
      io_limit = (cfg == 0) ? 16'h0BFF : 16'h0100;
      for (int mode = 0; mode < 4; mode++) begin
        vga_en = mode[1];
        isa_en = mode[0];
        idle_cycle();
        for (int a = 0; a < 'h2000; a++) begin
          step(1'b1, 32'(a), "");
        end
      end
    end

    // Memory sweeps: windows covering part of the legacy hole, then both empty
    for (int cfg = 0; cfg < 2; cfg++) begin
      mem_base   = (cfg == 0) ? 32'h000A_8000 : 32'h0020_0000;
      mem_limit  = (cfg == 0) ? 32'h000B_7FFF : 32'h000F_FFFF;
      pmem_base  = (cfg == 0) ? 32'h000C_0000 : 32'h0030_0000;
      pmem_limit = (cfg == 0) ? 32'h000C_0FFF : 32'h0000_1000;
      for (int mode = 0; mode < 4; mode++) begin
        vga_en = mode[1];
        isa_en = mode[0];
        idle_cycle();
        for (int a = 'h9F000; a < 'hC2000; a += 'h40) begin
          step(1'b0, 32'(a), "");
        end
      end
    end

    // Window edges (R7) and both memory windows (R8)
    mem_base   = 32'h000A_8000;
    mem_limit  = 32'h000B_7FFF;
    pmem_base  = 32'h000C_0000;
    pmem_limit = 32'h000C_0FFF;
    vga_en = 1'b0;
    isa_en = 1'b0;
    idle_cycle();
    step(1'b0, 32'h000A_7FFF, "R7");
    step(1'b0, 32'h000A_8000, "R7");
    step(1'b0, 32'h000B_7FFF, "R7");
    step(1'b0, 32'h000B_8000, "R7");
    step(1'b0, 32'h000B_FFFF, "R8");
    step(1'b0, 32'h000C_0000, "R8");
    step(1'b0, 32'h000C_0FFF, "R8");
    step(1'b0, 32'h000C_1000, "R8");
    // I/O window compares only the low 16 address bits (R10)
    io_base  = 16'h0300;
    io_limit = 16'h0BFF;
    step(1'b1, 32'h0001_0300, "R10");
    step(1'b1, 32'h0001_0C00, "R10");

    // Legacy memory hole edges with display forwarding on (R3)
    vga_en = 1'b1;
    idle_cycle();
    step(1'b0, 32'h0009_FFFF, "R3");
    step(1'b0, 32'h000A_0000, "R3");
    step(1'b0, 32'h000B_FFFF, "R3");
    step(1'b0, 32'h000C_1000, "R3");
    idle_cycle();

    summary();
    $finish;
  end

endmodule